// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block decides which peripheral interrupt a small 8-bit core services next and supplies the fetch address for that service routine. Each source is configured when the block is built as either an event source, whose pulses are caught in a sticky pending flag, or a level source, which requests service only while its input is high and keeps no memory. Software-visible enables arrive per source, a global enable bit lives inside the block, and a table-select input chooses between a vector table at address zero and one at a configurable boot base.

The core reports instruction completions (`instr_boundary_i`) and strobes for the return-from-handler, set-global-enable and clear-global-enable instructions. At a boundary where the global enable is on and an enabled request exists, the block raises `irq_take_o` in the same cycle with the winning slot and vector address. The acceptance masks further interrupts and clears the served event flag. Slot 0 belongs to reset, so peripheral source bit i uses slot i+1, and each slot spans two address words.

Top module: `irq_vector_ctrl`

## Requirements
- R1: An event-type source pulse sets its pending flag (`flags_o` bit i for source bit i) on the next clock edge whatever the per-source and global enables are, and the flag stays set until it is served or cleared.
- R2: With `clr_we_i` high, each `clr_mask_i` bit at 1 clears the matching event flag on the next edge; a new event on that source in the same cycle wins and leaves the flag set.
- R3: A level-type source never shows a flag (its `flags_o` bit reads 0) and requests only while its input and its enable are both 1; a condition that drops before it is enabled causes no acceptance.
- R4: Among the enabled requests, the lowest source bit wins; `irq_slot_o` is that bit index plus 1, and `vec_addr_o` is base + 2 × slot, where base is 0 when `vsel_i` is 0 and the boot base when it is 1.
- R5: `irq_take_o` is high exactly in a cycle where `instr_boundary_i` is high, the global enable is 1, some enabled request exists, and neither `cli_i` nor `reti_i` is high.
- R6: An acceptance clears the global enable and the served event flag on the next edge (unless a new event on that source arrives in the same cycle).
- R7: `reti_i` sets the global enable on the next edge, and no acceptance happens in the `reti_i` cycle, so at least one main-program instruction completes before the next service.
- R8: After reset the global enable and all flags are 0. `sei_i` sets the global enable on the next edge; `cli_i` blocks acceptance in its own cycle, clears the enable on the next edge, and wins over `sei_i` and `reti_i`.
- R9: Flags that became pending while masked are served one at a time in priority order once the global enable is set again; a handler that sets the global enable may be preempted by any enabled request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NUM_SRC | Event pulses or level conditions, one bit per source |
| en_i | input | NUM_SRC | Per-source enables |
| vsel_i | input | 1 | Vector table select: 0 = address 0, 1 = boot base |
| clr_we_i | input | 1 | Write strobe for flag clearing |
| clr_mask_i | input | NUM_SRC | Write-one-to-clear flag mask |
| instr_boundary_i | input | 1 | An instruction completed in this cycle |
| reti_i | input | 1 | Return-from-handler completed |
| sei_i | input | 1 | Set global enable instruction |
| cli_i | input | 1 | Clear global enable instruction |
| irq_take_o | output | 1 | Interrupt accepted this cycle |
| irq_slot_o | output | SLOT_W | Winning vector slot (source bit + 1) |
| vec_addr_o | output | ADDR_W | Vector fetch address |
| gie_o | output | 1 | Current global enable |
| flags_o | output | NUM_SRC | Pending event flags |

## Verification
The properties assume the core raises `reti_i` only together with an instruction boundary and that the reset seen by the logic is the internally synchronised one, so the checker is released by that same signal. They also presume `src_i` level conditions and event pulses are sampled on clock edges only. The stimulus keeps `sei_i`, `cli_i` and `reti_i` to at most one per cycle in its random phase and pairs `reti_i` with a boundary, while directed steps deliberately stack `cli_i` on a request and a new event on a clear to exercise the stated precedences.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;

  // Update applied to the global enable bit in a cycle.
  typedef enum logic [1:0] {
    GIE_KEEP = 2'd0,
    GIE_ON   = 2'd1,
    GIE_OFF  = 2'd2
  } gie_op_e;

  // Slot 0 is reserved for reset, so N sources need slots 0..N.
  function automatic int unsigned slot_width(int unsigned n_src);
    return (n_src < 2) ? 1 : $clog2(n_src + 1);
  endfunction

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int                  N_SRC = 8,
  parameter logic [N_SRC-1:0]    LVL   = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             clr_we_i,
  input  logic [N_SRC-1:0] clr_mask_i,
  input  logic [N_SRC-1:0] served_i,
  output logic [N_SRC-1:0] flags_o,
  output logic [N_SRC-1:0] req_o
);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (LVL[i]) begin : g_level
      // No storage: the condition itself is the request.
      logic unused_bits;
      assign unused_bits = clr_mask_i[i] ^ served_i[i];
      assign flags_o[i]  = 1'b0;
      assign req_o[i]    = src_i[i] & en_i[i];
    end else begin : g_event
      logic flag_q;
      logic flag_d;
      logic flag_ce;

      always_comb begin
        // A new event always wins over clearing.
        flag_ce = src_i[i] | (clr_we_i & clr_mask_i[i]) | served_i[i];
        flag_d  = src_i[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flag_q <= 1'b0;
        end else if (flag_ce) begin
          flag_q <= flag_d;
        end
      end

      assign flags_o[i] = flag_q;
      assign req_o[i]   = flag_q & en_i[i];
    end
  end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N_SRC  = 8,
  parameter int SLOT_W = 4
) (
  input  logic [N_SRC-1:0]  req_i,
  output logic              any_o,
  output logic [N_SRC-1:0]  grant_o,
  output logic [SLOT_W-1:0] slot_o
);

  always_comb begin
    grant_o = '0;
    slot_o  = '0;
    // Walk from the highest bit down so the lowest index is left standing.
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        slot_o     = SLOT_W'(i + 1);
      end
    end
    any_o = |req_i;
  end

endmodule

// File: rtl/irq_gie_ctrl.sv
module irq_gie_ctrl
  import irq_vector_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  input  logic sei_i,
  input  logic cli_i,
  input  logic reti_i,
  output logic gie_o
);

  gie_op_e op;
  logic    gie_q;
  logic    gie_d;

  always_comb begin
    op = GIE_KEEP;
    if (take_i || cli_i) begin
      op = GIE_OFF;
    end else if (sei_i || reti_i) begin
      op = GIE_ON;
    end
    gie_d = (op == GIE_ON);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
    end else if (op != GIE_KEEP) begin
      gie_q <= gie_d;
    end
  end

  assign gie_o = gie_q;

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vector_pkg::*;
#(
  parameter int                  NUM_SRC    = 8,
  parameter logic [NUM_SRC-1:0]  LEVEL_MASK = 8'hC0,
  parameter int                  ADDR_W     = 16,
  parameter logic [ADDR_W-1:0]   BOOT_BASE  = 16'h1C00,
  localparam int                 SLOT_W     = slot_width(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               vsel_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] clr_mask_i,
  input  logic               instr_boundary_i,
  input  logic               reti_i,
  input  logic               sei_i,
  input  logic               cli_i,
  output logic               irq_take_o,
  output logic [SLOT_W-1:0]  irq_slot_o,
  output logic [ADDR_W-1:0]  vec_addr_o,
  output logic               gie_o,
  output logic [NUM_SRC-1:0] flags_o
);

  logic               rst_n_s;
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] grant;
  logic [NUM_SRC-1:0] served;
  logic               any_req;
  logic [SLOT_W-1:0]  slot;
  logic               gie;
  logic               take;
  logic [ADDR_W-1:0]  base;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  irq_flag_bank #(.N_SRC(NUM_SRC), .LVL(LEVEL_MASK)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .src_i      (src_i),
    .en_i       (en_i),
    .clr_we_i   (clr_we_i),
    .clr_mask_i (clr_mask_i),
    .served_i   (served),
    .flags_o    (flags_o),
    .req_o      (req)
  );

  irq_prio_enc #(.N_SRC(NUM_SRC), .SLOT_W(SLOT_W)) u_prio (
    .req_i   (req),
    .any_o   (any_req),
    .grant_o (grant),
    .slot_o  (slot)
  );

  // Acceptance: boundary, enabled, something pending, and neither a
  // same-cycle disable nor the return cycle itself.
  always_comb begin
    take   = instr_boundary_i & gie & any_req & ~cli_i & ~reti_i;
    served = take ? grant : '0;
    base   = vsel_i ? BOOT_BASE : '0;
  end

  irq_gie_ctrl u_gie (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .take_i (take),
    .sei_i  (sei_i),
    .cli_i  (cli_i),
    .reti_i (reti_i),
    .gie_o  (gie)
  );

  assign irq_take_o = take;
  assign irq_slot_o = slot;
  assign vec_addr_o = base + (ADDR_W'(slot) << 1);
  assign gie_o      = gie;

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int              N   = 8,
  parameter logic [N-1:0]    LVL = '0,
  parameter int              SW  = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  src,
  input logic [N-1:0]  en,
  input logic          bnd,
  input logic          reti,
  input logic          cli,
  input logic          take,
  input logic [SW-1:0] slot,
  input logic          gie,
  input logic [N-1:0]  flags
);

  logic [N-1:0] req_vec;
  logic [N-1:0] lower_mask;
  logic [N-1:0] slot_bit;

  always_comb begin
    req_vec = en & ((flags & ~LVL) | (src & LVL));
    for (int i = 0; i < N; i++) begin
      lower_mask[i] = (SW'(i + 1) < slot);
      slot_bit[i]   = (SW'(i + 1) == slot);
    end
  end

  // R5
  a_r5_take_gated: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (bnd && gie && !cli && !reti));

  // R5
  a_r5_take_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (|req_vec));

  // R4
  a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (((req_vec & lower_mask) == '0) && (|(req_vec & slot_bit))));

  // R6
  a_r6_take_masks: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie);

  // R7
  a_r7_reti_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !cli) |=> gie);

  // R8
  a_r8_cli_disables: assert property (@(posedge clk) disable iff (!rst_n)
    cli |=> !gie);

  // R3
  a_r3_level_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & LVL) == '0);

  // R1
  a_r1_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src & ~LVL)) |=> ((flags & $past(src & ~LVL)) == $past(src & ~LVL)));

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .N   (NUM_SRC),
  .LVL (LEVEL_MASK),
  .SW  (SLOT_W)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n_s),
  .src   (src_i),
  .en    (en_i),
  .bnd   (instr_boundary_i),
  .reti  (reti_i),
  .cli   (cli_i),
  .take  (irq_take_o),
  .slot  (irq_slot_o),
  .gie   (gie_o),
  .flags (flags_o)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;

  localparam int              N     = 8;
  localparam logic [N-1:0]    LVL   = 8'hC0;
  localparam int              AW    = 16;
  localparam logic [AW-1:0]   BOOT  = 16'h1C00;
  localparam int              SW    = 4;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  src, en, clr_mask;
  logic          vsel, clr_we, bnd, reti, sei, cli;
  logic          take;
  logic [SW-1:0] slot;
  logic [AW-1:0] vaddr;
  logic          gie;
  logic [N-1:0]  flags;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;
  string phase = "R8 reset";

  // Behavioural reference state
  bit [N-1:0] m_flags;
  bit         m_gie;

  irq_vector_ctrl #(
    .NUM_SRC(N), .LEVEL_MASK(LVL), .ADDR_W(AW), .BOOT_BASE(BOOT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .en_i(en), .vsel_i(vsel),
    .clr_we_i(clr_we), .clr_mask_i(clr_mask), .instr_boundary_i(bnd),
    .reti_i(reti), .sei_i(sei), .cli_i(cli), .irq_take_o(take),
    .irq_slot_o(slot), .vec_addr_o(vaddr), .gie_o(gie), .flags_o(flags)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL [%s] %s: actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  // One cycle: drive at the falling edge, compare, advance the model.
  task automatic step(input logic [N-1:0] s, input logic [N-1:0] e, input logic v,
                      input logic cw, input logic [N-1:0] cm,
                      input logic b, input logic r, input logic se, input logic cl);
    int win;
    bit any, exp_take;
    bit [N-1:0] req;
    @(negedge clk);
    src = s; en = e; vsel = v; clr_we = cw; clr_mask = cm;
    bnd = b; reti = r; sei = se; cli = cl;
    #1;
    win = -1;
    for (int i = 0; i < N; i++) begin
      req[i] = e[i] && (LVL[i] ? s[i] : m_flags[i]);
      if (req[i] && win < 0) win = i;
    end
    any = (win >= 0);
    exp_take = b && m_gie && any && !cl && !r;
    chk(gie == m_gie, "R8 global enable", gie, m_gie);
    chk(flags == m_flags, "R1 flags", flags, m_flags);
    chk(take == exp_take, "R5 take", take, exp_take);
    if (exp_take && take) begin
      chk(slot == SW'(win + 1), "R4 slot", slot, win + 1);
      chk(vaddr == (v ? BOOT : AW'(0)) + AW'(2 * (win + 1)), "R4 vector address",
          vaddr, (v ? BOOT : AW'(0)) + AW'(2 * (win + 1)));
    end
    for (int i = 0; i < N; i++) begin
      if (LVL[i]) m_flags[i] = 1'b0;
      else begin
        if (cw && cm[i]) m_flags[i] = 1'b0;
        if (exp_take && win == i) m_flags[i] = 1'b0;
        if (s[i]) m_flags[i] = 1'b1;
      end
    end
    if (exp_take || cl) m_gie = 1'b0;
    else if (se || r) m_gie = 1'b1;
  endtask

  task automatic idle(input int n, input logic [N-1:0] e);
    for (int k = 0; k < n; k++) step('0, e, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL [watchdog] run did not finish: actual=timeout expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0; src = '0; en = '0; vsel = 1'b0; clr_we = 1'b0; clr_mask = '0;
    bnd = 1'b0; reti = 1'b0; sei = 1'b0; cli = 1'b0;
    m_flags = '0; m_gie = 1'b0;
    // R8: reset state
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(gie == 1'b0, "R8 reset gie", gie, 0);
      chk(flags == '0, "R8 reset flags", flags, 0);
      chk(take == 1'b0, "R8 reset take", take, 0);
    end
    @(negedge clk); rst_n = 1'b1;
    idle(4, '0);

    // R1: events latch while every enable is off
    phase = "R1 masked latch";
    step(8'h09, '0, 0, 0, '0, 1, 0, 0, 0);
    idle(2, '0);
    step('0, 8'hFF, 0, 0, '0, 1, 0, 0, 0);

    // R9: set global enable, served in priority order, reti then next
    phase = "R9 ordered service";
    step('0, 8'hFF, 0, 0, '0, 0, 0, 1, 0);
    step('0, 8'hFF, 0, 0, '0, 1, 0, 0, 0); // takes source 0
    idle(2, 8'hFF);
    phase = "R7 reti blocks";
    step('0, 8'hFF, 0, 0, '0, 1, 1, 0, 0); // no take in reti cycle
    step('0, 8'hFF, 0, 0, '0, 1, 0, 0, 0); // takes source 3
    // R9: nesting inside a handler
    phase = "R9 nesting";
    step(8'h04, 8'hFF, 0, 0, '0, 1, 0, 1, 0);
    step('0, 8'hFF, 0, 0, '0, 1, 0, 0, 0);
    step('0, 8'hFF, 0, 0, '0, 1, 1, 0, 0);

    // R8: cli beats a same-cycle request and a same-cycle sei
    phase = "R8 cli immediate";
    step(8'h02, 8'hFF, 0, 0, '0, 1, 0, 1, 0);
    step('0, 8'hFF, 0, 0, '0, 1, 0, 0, 1);
    step('0, 8'hFF, 0, 0, '0, 1, 0, 1, 1);
    idle(2, 8'hFF);

    // R2: write-one-to-clear, and event beats clear
    phase = "R2 clear";
    step(8'h30, '0, 0, 0, '0, 1, 0, 0, 0);
    step(8'h10, '0, 0, 1, 8'h32, 1, 0, 0, 0);
    idle(1, '0);

    // R3: level condition gone before enable never fires
    phase = "R3 level";
    step('0, '0, 0, 0, '0, 1, 0, 1, 0);
    step(8'h80, 8'h3F, 0, 0, '0, 1, 0, 0, 0);
    step('0, 8'hFF, 0, 0, '0, 1, 0, 0, 0);
    step(8'h40, 8'hFF, 0, 0, '0, 1, 0, 0, 0);
    step('0, 8'hFF, 0, 0, '0, 1, 1, 0, 0);

    // R4: boot-base table select
    phase = "R4 boot table";
    step(8'h20, 8'hFF, 1, 0, '0, 0, 0, 0, 0);
    step('0, 8'hFF, 1, 0, '0, 1, 0, 0, 0);
    step('0, 8'hFF, 1, 0, '0, 1, 1, 0, 0);

    // Mixed random traffic, R6 side effects checked every cycle
    phase = "R6 random";
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] s;
      int pick;
      logic b, r, se, cl;
      s = (N'($urandom) & N'($urandom) & N'($urandom) & ~LVL) | (N'($urandom) & LVL);
      b = ($urandom % 4) != 0;
      pick = $urandom % 12;
      r = (pick == 0); se = (pick == 1); cl = (pick == 2);
      if (r) b = 1'b1;
      step(s, N'($urandom), 1'($urandom), ($urandom % 8) == 0, N'($urandom),
           b, r, se, cl);
    end

    summary();
  end

endmodule